// File: doc/BRIEF.md
# Supply Power-Up Sequencer

This block decides when each of four supply channels may start ramping its gate drive. It gathers the board-level start inputs: an enable with a programmable active level, a power-on request with a programmable active level, and two active-low seating inputs. It also takes per-channel flags for bus-side voltage good, card-side voltage near zero, card-side voltage at threshold, channel enable and soft-start marking. Its outputs are a per-channel ramp enable, a per-channel gate clamp and a charge-pump enable. It does not generate the analog ramps and does not control slew rate.

Channels marked soft-start ramp first. The remaining enabled channels are the tracking channels. They wait until every enabled soft-start channel reports that its card-side voltage has reached threshold, and then they all ramp together. A forced shutdown input, whose active level is also programmable, clamps every gate at once. A crowbar event clamps every gate from the next cycle. After either kind of shutdown, the sequence restarts only once the run conditions have dropped and then come back.

The registered outputs follow the next state, so every output except the forced-shutdown override changes one clock after the inputs that cause it.

Top module: `supply_seq`

## Requirements
- R1: While reset is asserted and right after it, ramp_en, gate_clamp and pump_en are all zero and the block is in standby.
- R2: The enable input is active when en_in equals cfg_en_pol (0 means active low). pump_en rises on the clock edge after the enable becomes active.
- R3: Ramping starts only when seat_a_n and seat_b_n are both 0 and pwr_in equals cfg_pwr_pol (0 means active low).
- R4: Ramping starts only when every enabled channel has bus_ok=1 and card_zero=1. Channels with ch_enable=0 are left out of both checks.
- R5: When at least one enabled channel has soft_mark=1, only the enabled soft channels ramp at first. The other enabled channels join on the edge after every enabled soft channel shows card_at_thr=1.
- R6: When no enabled channel is soft-marked, all enabled channels receive ramp_en on the edge after the start conditions hold.
- R7: A channel with ch_enable=0 never receives ramp_en.
- R8: If the seating, power-on or bus-good conditions fail during a ramp, all ramp_en bits drop on the next edge. A restart requires the near-zero check again.
- R9: When force_sd_in equals cfg_sd_pol, gate_clamp is all ones and ramp_en is zero in the same cycle. After the next edge the block holds shutdown.
- R10: When crowbar_evt is 1, gate_clamp is all ones and ramp_en is zero from the next edge.
- R11: Shutdown holds gate_clamp high, even after the shutdown causes clear, until the run conditions drop. The sequence then restarts from waiting once the conditions return.
- R12: When the enable goes inactive outside shutdown, pump_en and all ramp_en bits fall on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en_pol | input | 1 | Active level of en_in |
| cfg_pwr_pol | input | 1 | Active level of pwr_in |
| cfg_sd_pol | input | 1 | Active level of force_sd_in |
| en_in | input | 1 | Standby exit / charge-pump enable request |
| pwr_in | input | 1 | Final power-on request |
| seat_a_n | input | 1 | First seating input, active low |
| seat_b_n | input | 1 | Second seating input, active low |
| ch_enable | input | N_CH | Channel is in use |
| soft_mark | input | N_CH | Channel is soft-start |
| bus_ok | input | N_CH | Bus-side voltage above its under-voltage level |
| card_zero | input | N_CH | Card-side voltage near zero |
| card_at_thr | input | N_CH | Card-side voltage at its threshold |
| force_sd_in | input | 1 | Forced shutdown request |
| crowbar_evt | input | 1 | Crowbar event |
| ramp_en | output | N_CH | Channel may ramp its gate |
| gate_clamp | output | N_CH | Gate held at ground |
| pump_en | output | 1 | Charge pump and reference on |

## Verification
A wrong state register shows up at the ports on the very next edge, because ramp_en, gate_clamp and pump_en are registered from the next state. The bench runs its own model of the sequencer and compares it with the design on every cycle, so a state that is off by one step fails within a cycle. A wrong soft/tracking split shows up as a tracking channel ramping early. A wrong shutdown exit shows up as the clamp releasing while the run conditions are still present.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_WAIT    = 3'd1,
        ST_SOFT    = 3'd2,
        ST_TRACK   = 3'd3,
        ST_ON      = 3'd4,
        ST_HALT    = 3'd5
    } seq_state_e;
endpackage

// File: rtl/supply_seq_cond.sv
module supply_seq_cond #(
    parameter int N_CH = 4
) (
    input  logic            en_in,
    input  logic            en_pol,
    input  logic            pwr_in,
    input  logic            pwr_pol,
    input  logic            sd_in,
    input  logic            sd_pol,
    input  logic            seat_a_n,
    input  logic            seat_b_n,
    input  logic [N_CH-1:0] ch_enable,
    input  logic [N_CH-1:0] soft_mark,
    input  logic [N_CH-1:0] bus_ok,
    input  logic [N_CH-1:0] card_zero,
    input  logic [N_CH-1:0] card_at_thr,
    output logic            en_act,
    output logic            sd_act,
    output logic            run_ok,
    output logic            start_ok,
    output logic            soft_any,
    output logic            soft_done,
    output logic            all_done
);
    logic [N_CH-1:0] bus_bad;
    logic [N_CH-1:0] zero_bad;
    logic [N_CH-1:0] soft_sel;
    logic [N_CH-1:0] soft_wait;
    logic [N_CH-1:0] ch_wait;
    logic            pwr_act;
    logic            seated;

    // per-channel qualification: disabled channels drop out of every check
    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            assign bus_bad[i]   = ch_enable[i] & ~bus_ok[i];
            assign zero_bad[i]  = ch_enable[i] & ~card_zero[i];
            assign soft_sel[i]  = ch_enable[i] & soft_mark[i];
            assign soft_wait[i] = soft_sel[i] & ~card_at_thr[i];
            assign ch_wait[i]   = ch_enable[i] & ~card_at_thr[i];
        end
    endgenerate

    always_comb begin
        en_act    = (en_in == en_pol);
        pwr_act   = (pwr_in == pwr_pol);
        sd_act    = (sd_in == sd_pol);
        seated    = ~seat_a_n & ~seat_b_n;
        run_ok    = en_act & seated & pwr_act & ~(|bus_bad);
        start_ok  = run_ok & ~(|zero_bad);
        soft_any  = |soft_sel;
        soft_done = ~(|soft_wait);
        all_done  = ~(|ch_wait);
    end
endmodule

// File: rtl/supply_seq_fsm.sv
module supply_seq_fsm
    import supply_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_act,
    input  logic       sd_act,
    input  logic       crowbar,
    input  logic       run_ok,
    input  logic       start_ok,
    input  logic       soft_any,
    input  logic       soft_done,
    input  logic       all_done,
    output seq_state_e state_d,
    output seq_state_e state_q
);
    typedef struct packed {
        seq_state_e st;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sd_act || crowbar) begin
            r_d.st = ST_HALT;
        end else if (r_q.st != ST_HALT && !en_act) begin
            r_d.st = ST_STANDBY;
        end else begin
            unique case (r_q.st)
                ST_STANDBY: r_d.st = ST_WAIT;
                ST_WAIT: begin
                    if (start_ok) r_d.st = soft_any ? ST_SOFT : ST_TRACK;
                end
                ST_SOFT: begin
                    if (!run_ok)        r_d.st = ST_WAIT;
                    else if (soft_done) r_d.st = ST_TRACK;
                end
                ST_TRACK: begin
                    if (!run_ok)       r_d.st = ST_WAIT;
                    else if (all_done) r_d.st = ST_ON;
                end
                ST_ON: begin
                    if (!run_ok) r_d.st = ST_WAIT;
                end
                ST_HALT: begin
                    if (!run_ok) r_d.st = en_act ? ST_WAIT : ST_STANDBY;
                end
                default: r_d.st = ST_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_STANDBY};
        else        r_q <= r_d;
    end

    assign state_d = r_d.st;
    assign state_q = r_q.st;
endmodule

// File: rtl/supply_seq_drive.sv
module supply_seq_drive
    import supply_seq_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_e      state_d,
    input  logic [N_CH-1:0] ch_enable,
    input  logic [N_CH-1:0] soft_mark,
    input  logic            sd_act,
    output logic [N_CH-1:0] ramp_en,
    output logic [N_CH-1:0] gate_clamp,
    output logic            pump_en
);
    typedef struct packed {
        logic [N_CH-1:0] ramp;
        logic [N_CH-1:0] clamp;
        logic            pump;
    } drv_t;

    drv_t o_d, o_q;

    always_comb begin
        o_d.pump  = (state_d != ST_STANDBY);
        o_d.clamp = (state_d == ST_HALT) ? '1 : '0;
        unique case (state_d)
            ST_SOFT:         o_d.ramp = ch_enable & soft_mark;
            ST_TRACK, ST_ON: o_d.ramp = ch_enable;
            default:         o_d.ramp = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    // forced shutdown acts without waiting for a clock edge
    assign ramp_en    = o_q.ramp & ~{N_CH{sd_act}};
    assign gate_clamp = o_q.clamp | {N_CH{sd_act}};
    assign pump_en    = o_q.pump;
endmodule

// File: rtl/supply_seq.sv
module supply_seq
    import supply_seq_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en_pol,
    input  logic            cfg_pwr_pol,
    input  logic            cfg_sd_pol,
    input  logic            en_in,
    input  logic            pwr_in,
    input  logic            seat_a_n,
    input  logic            seat_b_n,
    input  logic [N_CH-1:0] ch_enable,
    input  logic [N_CH-1:0] soft_mark,
    input  logic [N_CH-1:0] bus_ok,
    input  logic [N_CH-1:0] card_zero,
    input  logic [N_CH-1:0] card_at_thr,
    input  logic            force_sd_in,
    input  logic            crowbar_evt,
    output logic [N_CH-1:0] ramp_en,
    output logic [N_CH-1:0] gate_clamp,
    output logic            pump_en
);
    logic       en_act, sd_act, run_ok, start_ok;
    logic       soft_any, soft_done, all_done;
    seq_state_e state_d, state_q;

    supply_seq_cond #(.N_CH(N_CH)) u_cond (
        .en_in      (en_in),
        .en_pol     (cfg_en_pol),
        .pwr_in     (pwr_in),
        .pwr_pol    (cfg_pwr_pol),
        .sd_in      (force_sd_in),
        .sd_pol     (cfg_sd_pol),
        .seat_a_n   (seat_a_n),
        .seat_b_n   (seat_b_n),
        .ch_enable  (ch_enable),
        .soft_mark  (soft_mark),
        .bus_ok     (bus_ok),
        .card_zero  (card_zero),
        .card_at_thr(card_at_thr),
        .en_act     (en_act),
        .sd_act     (sd_act),
        .run_ok     (run_ok),
        .start_ok   (start_ok),
        .soft_any   (soft_any),
        .soft_done  (soft_done),
        .all_done   (all_done)
    );

    supply_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_act   (en_act),
        .sd_act   (sd_act),
        .crowbar  (crowbar_evt),
        .run_ok   (run_ok),
        .start_ok (start_ok),
        .soft_any (soft_any),
        .soft_done(soft_done),
        .all_done (all_done),
        .state_d  (state_d),
        .state_q  (state_q)
    );

    supply_seq_drive #(.N_CH(N_CH)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .ch_enable (ch_enable),
        .soft_mark (soft_mark),
        .sd_act    (sd_act),
        .ramp_en   (ramp_en),
        .gate_clamp(gate_clamp),
        .pump_en   (pump_en)
    );
endmodule

// File: rtl/supply_seq_chk.sv
module supply_seq_chk
    import supply_seq_pkg::*;
#(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_en_pol,
    input logic            cfg_sd_pol,
    input logic            en_in,
    input logic            seat_a_n,
    input logic            seat_b_n,
    input logic [N_CH-1:0] ch_enable,
    input logic            force_sd_in,
    input logic            crowbar_evt,
    input logic [N_CH-1:0] ramp_en,
    input logic [N_CH-1:0] gate_clamp,
    input logic            pump_en,
    input seq_state_e      state_q
);
    logic past_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    AST_SD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (force_sd_in == cfg_sd_pol) |-> ((&gate_clamp) && ramp_en == '0)); // R9

    AST_CROWBAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        crowbar_evt |=> ((&gate_clamp) && ramp_en == '0)); // R10

    AST_NO_PUMP_NO_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_en |-> (ramp_en == '0)); // R12

    AST_STANDBY_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_in != cfg_en_pol) && (force_sd_in != cfg_sd_pol) && !crowbar_evt
         && state_q != ST_HALT) |=> !pump_en); // R2

    AST_DISABLED_NO_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> ((ramp_en & ~$past(ch_enable)) == '0)); // R7

    AST_RAMP_NEEDS_SEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && ramp_en != '0) |-> (!$past(seat_a_n) && !$past(seat_b_n))); // R3
endmodule

bind supply_seq supply_seq_chk #(.N_CH(N_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en_pol (cfg_en_pol),
    .cfg_sd_pol (cfg_sd_pol),
    .en_in      (en_in),
    .seat_a_n   (seat_a_n),
    .seat_b_n   (seat_b_n),
    .ch_enable  (ch_enable),
    .force_sd_in(force_sd_in),
    .crowbar_evt(crowbar_evt),
    .ramp_en    (ramp_en),
    .gate_clamp (gate_clamp),
    .pump_en    (pump_en),
    .state_q    (state_q)
);

// File: tb/sim_supply_seq.sv
`timescale 1ns/1ps
module sim_supply_seq;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en_pol = 1'b0, cfg_pwr_pol = 1'b0, cfg_sd_pol = 1'b0;
    logic en_in = 1'b1, pwr_in = 1'b1, seat_a_n = 1'b1, seat_b_n = 1'b1;
    logic [N-1:0] ch_enable = 4'b0111, soft_mark = 4'b0001;
    logic [N-1:0] bus_ok = 4'b0111, card_zero = 4'b1111, card_at_thr = 4'b0000;
    logic force_sd_in = 1'b1, crowbar_evt = 1'b0;
    logic [N-1:0] ramp_en, gate_clamp;
    logic pump_en;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // model state: 0 standby 1 wait 2 soft 3 track 4 on 5 halt
    int mst = 0;
    logic [N-1:0] m_ramp = '0, m_clamp = '0;
    logic m_pump = 1'b0;

    always #10 clk = ~clk;

    supply_seq #(.N_CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en_pol(cfg_en_pol), .cfg_pwr_pol(cfg_pwr_pol),
        .cfg_sd_pol(cfg_sd_pol), .en_in(en_in), .pwr_in(pwr_in), .seat_a_n(seat_a_n),
        .seat_b_n(seat_b_n), .ch_enable(ch_enable), .soft_mark(soft_mark), .bus_ok(bus_ok),
        .card_zero(card_zero), .card_at_thr(card_at_thr), .force_sd_in(force_sd_in),
        .crowbar_evt(crowbar_evt), .ramp_en(ramp_en), .gate_clamp(gate_clamp), .pump_en(pump_en)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst = 0; m_ramp = '0; m_clamp = '0; m_pump = 1'b0;
        end else begin
            bit ena, run, start, sany, sdone, adone, sd;
            ena = (en_in == cfg_en_pol);
            sd  = (force_sd_in == cfg_sd_pol);
            run = ena && !seat_a_n && !seat_b_n && (pwr_in == cfg_pwr_pol);
            start = 1; sany = 0; sdone = 1; adone = 1;
            for (int i = 0; i < N; i++) begin
                if (ch_enable[i]) begin
                    if (!bus_ok[i]) run = 0;
                    if (!card_zero[i]) start = 0;
                    if (!card_at_thr[i]) adone = 0;
                    if (soft_mark[i]) begin
                        sany = 1;
                        if (!card_at_thr[i]) sdone = 0;
                    end
                end
            end
            start = start && run;
            if (sd || crowbar_evt) mst = 5;
            else if (mst != 5 && !ena) mst = 0;
            else case (mst)
                0: mst = 1;
                1: if (start) mst = sany ? 2 : 3;
                2: if (!run) mst = 1; else if (sdone) mst = 3;
                3: if (!run) mst = 1; else if (adone) mst = 4;
                4: if (!run) mst = 1;
                5: if (!run) mst = ena ? 1 : 0;
                default: mst = 0;
            endcase
            m_pump  = (mst != 0);
            m_clamp = (mst == 5) ? '1 : '0;
            m_ramp  = (mst == 2) ? (ch_enable & soft_mark) :
                      (mst == 3 || mst == 4) ? ch_enable : '0;
        end
    end

    task automatic check(string req, logic [N-1:0] r, logic [N-1:0] c, logic p);
        logic [N-1:0] er, ec;
        bit sd;
        sd = (force_sd_in == cfg_sd_pol) && rst_n;
        er = sd ? '0 : m_ramp;
        ec = sd ? '1 : m_clamp;
        checks++;
        if (r !== er || c !== ec || p !== m_pump) begin
            errors++;
            $display("FAIL %s t=%0t ramp=%b/%b clamp=%b/%b pump=%b/%b (actual/expected)",
                     req, $time, r, er, c, ec, p, m_pump);
        end
    endtask

    always @(negedge clk) if (rst_n) check(cur_req, ramp_en, gate_clamp, pump_en);

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #5;
        check("R1", ramp_en, gate_clamp, pump_en);
        step(2);
        rst_n = 1'b1;
        step(1);
        check("R1", ramp_en, gate_clamp, pump_en);
        // enable active low by default; channel 3 disabled with bad bus
        cur_req = "R2"; en_in = 1'b0; step(3);
        cur_req = "R3"; seat_a_n = 1'b0; step(3);
        seat_b_n = 1'b0; step(3);
        cur_req = "R4"; pwr_in = 1'b0; card_zero = 4'b1101; step(3);
        card_zero = 4'b1111; step(3);
        cur_req = "R5"; card_zero = 4'b0000; step(4);
        card_at_thr = 4'b0001; step(3);
        cur_req = "R7"; card_at_thr = 4'b0111; step(3);
        cur_req = "R8"; seat_b_n = 1'b1; card_at_thr = 4'b0000; step(3);
        seat_b_n = 1'b0; step(3);
        card_zero = 4'b1111; step(2);
        cur_req = "R9"; force_sd_in = 1'b0; #3; check("R9", ramp_en, gate_clamp, pump_en);
        step(3);
        cur_req = "R11"; force_sd_in = 1'b1; step(4);
        pwr_in = 1'b1; step(2);
        pwr_in = 1'b0; step(3);
        cur_req = "R6"; soft_mark = 4'b0000; pwr_in = 1'b1; step(2);
        pwr_in = 1'b0; step(3);
        cur_req = "R10"; crowbar_evt = 1'b1; step(1); crowbar_evt = 1'b0; step(3);
        seat_a_n = 1'b1; step(2);
        cur_req = "R12"; en_in = 1'b1; seat_a_n = 1'b0; step(3);
        // swap every polarity to active high
        cur_req = "R2"; cfg_en_pol = 1'b1; cfg_pwr_pol = 1'b1; cfg_sd_pol = 1'b1;
        force_sd_in = 1'b0; pwr_in = 1'b0; step(2);
        en_in = 1'b1; step(2);
        cur_req = "R3"; pwr_in = 1'b1; soft_mark = 4'b0010; step(3);
        cur_req = "R5"; card_at_thr = 4'b0010; step(3);
        cur_req = "R9"; force_sd_in = 1'b1; step(2); force_sd_in = 1'b0; en_in = 1'b0; step(3);
        cur_req = "R12"; step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule